// File: doc/BRIEF.md
# Token Bandwidth Manager

This block meters access to shared memory banks and I/O interface channels. Each requester is mapped by privileged configuration to an allocation group. Every group owns one token counter per managed resource class, and a per-group rate generator adds one token to each of that group's counters whenever its period expires. A request is granted in the cycle it is presented only if a token for the addressed class is available. The requester's own group is tried first. If it has none, the other groups are searched in a configured lending order, and the first group with a spare token supplies it.

When metering is switched off, every request is granted at once and no token is spent. A request that keeps failing because no group has a token raises a warning interrupt once its wait reaches a programmable number of cycles. The block only decides and accounts; the bus transfer itself happens elsewhere.

Top module: `bw_token_mgr`

## Requirements
- R1: While reset is held, no request is granted and `ovc_irq` is low; token counters and rate generators start from zero.
- R2: With `mgr_en` low, a presented request is granted in the same cycle with `grant_src` equal to the requester's own group and `grant_lent` low, and no token is consumed.
- R3: With `mgr_en` high and a token present in the requester's own group for the addressed class, the grant comes from the own group, with `grant_lent` low.
- R4: Each grant removes exactly one token from the supplying group's counter for the addressed class, at the clock edge that ends the grant cycle. A request for which no group holds a token is not granted.
- R5: Each group's generator adds one token to every class of that group on the first clock edge after reset release, and again every `period+1` edges, where `period` is field g of `grp_period` (bits `[g*PERIOD_W +: PERIOD_W]`). A counter never exceeds `tok_max`.
- R6: When the own group is empty, the lender is the first group in `lend_order` that holds a token, skipping the own group. Field k (bits `[k*GID_W +: GID_W]`) names the group at priority k, and k=0 is highest. Such a grant sets `grant_lent` high.
- R7: Counters of different classes are independent. Classes 0 to 15 are the memory banks, and classes 16 to 19 are the I/O channels (16 and 17 on the first interface, 18 and 19 on the second).
- R8: `ovc_irq` goes high at the clock edge on which a continuously refused request completes `wait_limit` waiting cycles. It stays high while the request keeps waiting and falls at the first edge at which no request is waiting.
- R9: Requester i belongs to the group held in bits `[i*GID_W +: GID_W]` of `req_group_map`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mgr_en | input | 1 | Metering enable; low grants everything |
| req_group_map | input | NUM_REQ*GID_W | Group of each requester |
| grp_period | input | NUM_GROUPS*PERIOD_W | Token period of each group |
| tok_max | input | TOK_W | Counter ceiling |
| lend_order | input | NUM_GROUPS*GID_W | Lending priority list of group numbers |
| wait_limit | input | WAIT_W | Waiting cycles before the warning |
| req_valid | input | 1 | A request is presented |
| req_id | input | REQ_W | Requester number |
| req_res | input | RES_W | Resource class addressed |
| req_grant | output | 1 | Request granted this cycle |
| grant_src | output | GID_W | Group that supplied the token |
| grant_lent | output | 1 | Token came from another group |
| ovc_irq | output | 1 | Overcommit warning |

## Verification
The hardest state to reach from the ports is a counter sitting at its ceiling while the other groups are drained. Token counts cannot be read, so saturation has to be inferred from the number of own-group grants before lending starts. The stimulus uses a short period for one group and periods longer than the test window for the others. Edges are counted from reset release so that a known number of ticks has passed before the requests, and a lender's class is emptied beforehand so that the borrowed grant also shows which group is next in the order. Exhausting every group for one class, and then holding the refused request, reaches the overcommit warning.

// File: rtl/bw_token_pkg.sv
package bw_token_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OWN  = 2'd1,
    SRC_LEND = 2'd2
  } src_kind_e;
endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/bw_rate_gen.sv
module bw_rate_gen #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] cnt_d;
  logic                cnt_en;

  always_comb begin
    tick   = (cnt_q == '0);
    cnt_en = 1'b1;
    cnt_d  = tick ? period : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bw_token_bank.sv
module bw_token_bank #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_RES    = 20,
  parameter int TOK_W      = 3,
  localparam int GID_W     = $clog2(NUM_GROUPS),
  localparam int RES_W     = $clog2(NUM_RES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] tick,
  input  logic [TOK_W-1:0]      tok_max,
  input  logic                  take_en,
  input  logic [GID_W-1:0]      take_grp,
  input  logic [RES_W-1:0]      take_res,
  input  logic [RES_W-1:0]      query_res,
  output logic [NUM_GROUPS-1:0] avail
);
  localparam int CELLS = NUM_GROUPS * NUM_RES;

  logic [CELLS-1:0] nonzero;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
      logic [TOK_W-1:0] cnt_q;
      logic [TOK_W-1:0] cnt_d;
      logic [TOK_W-1:0] after_take;
      logic             take;
      logic             cell_en;

      always_comb begin
        take       = take_en && (take_grp == GID_W'(g)) && (take_res == RES_W'(r));
        after_take = cnt_q - TOK_W'(take);
        cnt_d      = after_take;
        if (tick[g] && (after_take < tok_max)) begin
          cnt_d = after_take + 1'b1;
        end
        cell_en = take | tick[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cell_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign nonzero[g*NUM_RES + r] = (cnt_q != '0);
    end
  end

  always_comb begin
    avail = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int r = 0; r < NUM_RES; r++) begin
        if (query_res == RES_W'(r)) begin
          avail[g] = nonzero[g*NUM_RES + r];
        end
      end
    end
  end
endmodule

// File: rtl/bw_lend_arb.sv
module bw_lend_arb
  import bw_token_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GID_W     = $clog2(NUM_GROUPS)
) (
  input  logic [GID_W-1:0]            own_grp,
  input  logic [NUM_GROUPS-1:0]       avail,
  input  logic [NUM_GROUPS*GID_W-1:0] lend_order,
  output logic                        hit,
  output logic [GID_W-1:0]            src_grp,
  output logic                        lent
);
  src_kind_e        kind;
  logic [GID_W-1:0] cand;

  always_comb begin
    kind    = SRC_NONE;
    src_grp = own_grp;
    cand    = '0;
    if (avail[own_grp]) begin
      kind = SRC_OWN;
    end else begin
      for (int k = 0; k < NUM_GROUPS; k++) begin
        cand = lend_order[k*GID_W +: GID_W];
        if ((kind == SRC_NONE) && (cand != own_grp) && avail[cand]) begin
          kind    = SRC_LEND;
          src_grp = cand;
        end
      end
    end
    hit  = (kind != SRC_NONE);
    lent = (kind == SRC_LEND);
  end
endmodule

// File: rtl/bw_overcommit.sv
module bw_overcommit #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              waiting,
  input  logic [WAIT_W-1:0] limit,
  output logic              irq
);
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] wait_d;
  logic              irq_q;
  logic              irq_d;
  logic              upd_en;

  always_comb begin
    if (waiting) begin
      wait_d = (&wait_q) ? wait_q : wait_q + 1'b1;
    end else begin
      wait_d = '0;
    end
    irq_d  = waiting && (wait_d >= limit);
    upd_en = waiting | (wait_q != '0) | irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      wait_q <= wait_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/bw_token_mgr.sv
module bw_token_mgr #(
  parameter int NUM_GROUPS   = 4,
  parameter int NUM_BANKS    = 16,
  parameter int NUM_IO       = 2,
  parameter int CLASS_PER_IO = 2,
  parameter int NUM_REQ      = 8,
  parameter int TOK_W        = 3,
  parameter int PERIOD_W     = 8,
  parameter int WAIT_W       = 8,
  localparam int NUM_RES     = NUM_BANKS + NUM_IO * CLASS_PER_IO,
  localparam int GID_W       = $clog2(NUM_GROUPS),
  localparam int RES_W       = $clog2(NUM_RES),
  localparam int REQ_W       = $clog2(NUM_REQ)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mgr_en,
  input  logic [NUM_REQ*GID_W-1:0]       req_group_map,
  input  logic [NUM_GROUPS*PERIOD_W-1:0] grp_period,
  input  logic [TOK_W-1:0]               tok_max,
  input  logic [NUM_GROUPS*GID_W-1:0]    lend_order,
  input  logic [WAIT_W-1:0]              wait_limit,
  input  logic                           req_valid,
  input  logic [REQ_W-1:0]               req_id,
  input  logic [RES_W-1:0]               req_res,
  output logic                           req_grant,
  output logic [GID_W-1:0]               grant_src,
  output logic                           grant_lent,
  output logic                           ovc_irq
);
  logic                  rst_n_int;
  logic [NUM_GROUPS-1:0] tick;
  logic [NUM_GROUPS-1:0] avail;
  logic [GID_W-1:0]      own_grp;
  logic                  arb_hit;
  logic [GID_W-1:0]      arb_src;
  logic                  arb_lent;
  logic                  take_en;
  logic                  waiting;

  bw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rate
    bw_rate_gen #(.PERIOD_W(PERIOD_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .period (grp_period[g*PERIOD_W +: PERIOD_W]),
      .tick   (tick[g])
    );
  end

  always_comb begin
    own_grp = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_id == REQ_W'(i)) begin
        own_grp = req_group_map[i*GID_W +: GID_W];
      end
    end
  end

  bw_token_bank #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_RES    (NUM_RES),
    .TOK_W      (TOK_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .tok_max   (tok_max),
    .take_en   (take_en),
    .take_grp  (arb_src),
    .take_res  (req_res),
    .query_res (req_res),
    .avail     (avail)
  );

  bw_lend_arb #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
    .own_grp    (own_grp),
    .avail      (avail),
    .lend_order (lend_order),
    .hit        (arb_hit),
    .src_grp    (arb_src),
    .lent       (arb_lent)
  );

  always_comb begin
    take_en    = mgr_en && req_valid && arb_hit;
    req_grant  = req_valid && (!mgr_en || arb_hit);
    grant_src  = '0;
    grant_lent = 1'b0;
    if (req_grant) begin
      grant_src  = mgr_en ? arb_src : own_grp;
      grant_lent = mgr_en && arb_lent;
    end
    waiting = req_valid && !req_grant;
  end

  bw_overcommit #(.WAIT_W(WAIT_W)) u_ovc (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .waiting (waiting),
    .limit   (wait_limit),
    .irq     (ovc_irq)
  );
endmodule

// File: rtl/bw_token_mgr_chk.sv
module bw_token_mgr_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_REQ    = 8,
  localparam int GID_W     = $clog2(NUM_GROUPS),
  localparam int REQ_W     = $clog2(NUM_REQ)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mgr_en,
  input logic [NUM_REQ*GID_W-1:0] req_group_map,
  input logic                     req_valid,
  input logic [REQ_W-1:0]         req_id,
  input logic                     req_grant,
  input logic [GID_W-1:0]         grant_src,
  input logic                     grant_lent,
  input logic                     ovc_irq
);
  logic [GID_W-1:0] home;

  always_comb begin
    home = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_id == REQ_W'(i)) begin
        home = req_group_map[i*GID_W +: GID_W];
      end
    end
  end

  // R2
  bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mgr_en && req_valid) |-> (req_grant && !grant_lent && grant_src == home));

  // R4
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> req_valid);

  // R3
  own_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant && !grant_lent) |-> (grant_src == home));

  // R6
  lender_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_lent |-> (req_grant && mgr_en && grant_src != home));

  // R8
  irq_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_irq) |-> $past(req_valid && !req_grant));

  // R8
  irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_irq && !$past(req_valid && !req_grant)) |-> $fell(ovc_irq));
endmodule

bind bw_token_mgr bw_token_mgr_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .NUM_REQ    (NUM_REQ)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mgr_en        (mgr_en),
  .req_group_map (req_group_map),
  .req_valid     (req_valid),
  .req_id        (req_id),
  .req_grant     (req_grant),
  .grant_src     (grant_src),
  .grant_lent    (grant_lent),
  .ovc_irq       (ovc_irq)
);

// File: tb/bw_token_mgr_test.sv
module bw_token_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk;
  logic        rst_n;
  logic        mgr_en;
  logic [15:0] req_group_map;
  logic [31:0] grp_period;
  logic [2:0]  tok_max;
  logic [7:0]  lend_order;
  logic [7:0]  wait_limit;
  logic        req_valid;
  logic [2:0]  req_id;
  logic [4:0]  req_res;
  logic        req_grant;
  logic [1:0]  grant_src;
  logic        grant_lent;
  logic        ovc_irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // vector: {req tag[3:0], req_id[2:0], res[4:0], grant, src[1:0], lent}
  localparam logic [15:0] VEC [NV] = '{
    {4'd3, 3'd0, 5'd0,  1'b1, 2'd0, 1'b0},  // R3 own group
    {4'd6, 3'd1, 5'd0,  1'b1, 2'd3, 1'b1},  // R6 first in order
    {4'd4, 3'd0, 5'd0,  1'b1, 2'd1, 1'b1},  // R4 group 3 token spent
    {4'd6, 3'd2, 5'd0,  1'b1, 2'd2, 1'b1},  // R6 skip own group 1
    {4'd4, 3'd4, 5'd0,  1'b0, 2'd0, 1'b0},  // R4 nothing left
    {4'd7, 3'd0, 5'd1,  1'b1, 2'd0, 1'b0},  // R7 other bank untouched
    {4'd9, 3'd6, 5'd19, 1'b1, 2'd3, 1'b0},  // R9 requester 6 in group 3
    {4'd6, 3'd7, 5'd19, 1'b1, 2'd1, 1'b1},  // R6 own group 3 skipped
    {4'd7, 3'd5, 5'd16, 1'b1, 2'd2, 1'b0}   // R7 I/O class
  };

  bw_token_mgr uut (
    .clk(clk), .rst_n(rst_n), .mgr_en(mgr_en), .req_group_map(req_group_map),
    .grp_period(grp_period), .tok_max(tok_max), .lend_order(lend_order),
    .wait_limit(wait_limit), .req_valid(req_valid), .req_id(req_id),
    .req_res(req_res), .req_grant(req_grant), .grant_src(grant_src),
    .grant_lent(grant_lent), .ovc_irq(ovc_irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // presents one request for one cycle; outputs captured before the edge
  task automatic req_cycle(input logic [2:0] id, input logic [4:0] res,
                           output logic g, output logic [1:0] s, output logic l);
    @(negedge clk);
    req_valid = 1'b1;
    req_id    = id;
    req_res   = res;
    #1;
    g = req_grant;
    s = grant_src;
    l = grant_lent;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic g;
    logic [1:0] s;
    logic l;
    rst_n         = 1'b0;
    mgr_en        = 1'b1;
    req_group_map = {2'd3, 2'd3, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0};
    grp_period    = {8'd200, 8'd200, 8'd200, 8'd200};
    tok_max       = 3'd3;
    lend_order    = {2'd0, 2'd2, 2'd1, 2'd3};
    wait_limit    = 8'd4;
    req_valid     = 1'b0;
    req_id        = '0;
    req_res       = '0;

    // R1: held in reset, a request is refused and no warning shows
    repeat (2) @(negedge clk);
    req_valid = 1'b1;
    #1;
    check(req_grant == 1'b0, "R1 grant in reset", req_grant, 0);
    check(ovc_irq == 1'b0, "R1 irq in reset", ovc_irq, 0);
    req_valid = 1'b0;

    do_reset();
    #1;
    check(req_grant == 1'b0 && ovc_irq == 1'b0, "R1 idle after reset",
          {req_grant, ovc_irq}, 0);

    for (int v = 0; v < NV; v++) begin
      req_cycle(VEC[v][11:9], VEC[v][8:4], g, s, l);
      if (VEC[v][3]) begin
        check(g && s == VEC[v][2:1] && l == VEC[v][0],
              $sformatf("R%0d vector %0d grant/src/lent", VEC[v][15:12], v),
              {g, s, l}, VEC[v][3:0]);
      end else begin
        check(!g, $sformatf("R%0d vector %0d grant", VEC[v][15:12], v), g, 0);
      end
    end

    // R8: class 0 empty everywhere; hold a refused request
    @(negedge clk);
    req_valid = 1'b1;
    req_id    = 3'd4;
    req_res   = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ovc_irq == 1'b0, "R8 irq before limit", ovc_irq, 0);
    @(posedge clk);
    @(negedge clk);
    check(ovc_irq == 1'b1, "R8 irq at limit", ovc_irq, 1);
    check(req_grant == 1'b0, "R4 still refused", req_grant, 0);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(ovc_irq == 1'b0, "R8 irq clears", ovc_irq, 0);

    // R2: bypass grants without tokens and spends none
    mgr_en = 1'b0;
    req_cycle(3'd4, 5'd0, g, s, l);
    check(g && s == 2'd2 && !l, "R2 bypass grant", {g, s, l}, 4'b1100);
    req_cycle(3'd0, 5'd2, g, s, l);
    check(g && s == 2'd0 && !l, "R2 bypass own", {g, s, l}, 4'b1000);
    mgr_en = 1'b1;
    req_cycle(3'd1, 5'd2, g, s, l);
    check(g && s == 2'd0 && !l, "R2 token kept", {g, s, l}, 4'b1000);

    // R5: group 0 period 40, others beyond the window, ceiling 2
    grp_period = {8'd255, 8'd255, 8'd255, 8'd40};
    tok_max    = 3'd2;
    do_reset();
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd0 && !l, "R5 first token", {g, s, l}, 4'b1000);
    repeat (17) @(posedge clk);
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd3 && l, "R5 no token before period", {g, s, l}, 4'b1111);
    repeat (24) @(posedge clk);
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd0 && !l, "R5 token after period", {g, s, l}, 4'b1000);
    repeat (125) @(posedge clk);
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd0 && !l, "R5 saturated token 1", {g, s, l}, 4'b1000);
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd0 && !l, "R5 saturated token 2", {g, s, l}, 4'b1000);
    req_cycle(3'd0, 5'd5, g, s, l);
    check(g && s == 2'd1 && l, "R5 ceiling holds two", {g, s, l}, 4'b1011);

    finish_run();
  end
endmodule